// File: doc/BRIEF.md
# Per-Source Interrupt Controller

A memory-mapped controller that gathers 64 interrupt inputs and presents one interrupt request together with the number of the source being serviced. Each input has its own control byte. The byte gates the source and chooses whether the source is sensed as an active-high level, as a rising edge or as a falling edge. Raw inputs cross into the clock domain through a two-stage synchroniser before any detection takes place.

Edge events are held in two 32-bit status words until software clears them by writing ones. A source competes for service when it is enabled and either its synchronised level is high (level type) or its latched status bit is set (edge type). One global configuration bit chooses between fixed lowest-index priority and rotating priority. With rotating priority the search starts one past the last source granted.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control byte, both status words, the configuration registers at 0x20 and 0x24, `irq_o` and `irq_id_o` read 0.
- R2: The control byte of source n is at byte offset 0x40+n, packed four per 32-bit word (source n in bits 8*(n%4)+7 : 8*(n%4) of the word at 0x40+4*(n/4)). Bit 3 is the enable. It reads back as written.
- R3: Trigger field bits [5:4] = 0 selects high level. An enabled level source is pending while its synchronised input is high. `irq_o` rises on the third clock edge after the input rises and falls in the same way after the input drops.
- R4: Trigger field 1, and also 3, selects rising edge. A 0-to-1 change of the synchronised input sets the source's status bit, and the bit stays set after the input returns low.
- R5: Trigger field 2 selects falling edge. A 1-to-0 change of the synchronised input sets the status bit.
- R6: Status bits of sources 0..31 are in the word at 0x80, and those of sources 32..63 are in the word at 0x84, at bit position n%32.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When an edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: A source whose enable bit is 0 never drives `irq_o`. Its edge events are still latched in status.
- R10: With bit 6 of the register at 0x20 clear, the lowest-numbered pending source wins.
- R11: With bit 6 of 0x20 set, the search starts one past the last granted source and wraps at 63. Pending sources are therefore served in turn.
- R12: The word at 0x00 reads `irq_o` in bit 31 and the current winner number in bits [5:0].
- R13: The register at 0x24 is a 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| src_i | input | 64 | Raw interrupt inputs |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 6 | Number of the granted source |

## Verification
Edge latching and the software clear can act on the same status bit in the same cycle. The bench first latches an event, lets the input fall, and then raises it again. It places a write-one-to-clear so that the write is sampled on exactly the clock edge where the new rising edge reaches the status logic, two edges after the synchroniser captures the input. The bit must read back as set afterwards, and a lone clear of the same bit must read back as cleared.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RISE2 = 2'd3
  } trig_e;

  localparam int CTRL_EN_BIT = 3;
  localparam int TRIG_LSB    = 4;
  localparam int ROT_BIT     = 6;

  localparam int A_WIN  = 'h00;
  localparam int A_CFG  = 'h20;
  localparam int A_CFG2 = 'h24;
  localparam int A_CTRL = 'h40;
  localparam int A_STAT = 'h80;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_edge_stat.sv
module irq_edge_stat #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] prev_q, stat_q, set_vec;

  assign set_vec = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_i;
      stat_q <= (stat_q & ~clr_i) | set_vec; // new edge wins over clear
    end
  end

  assign stat_o = stat_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_vec[k]) |=> !stat_o[k]);
    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[k] |=> stat_o[k]);
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N    = 64,
  parameter int ID_W = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    pend_i,
  input  logic            rot_i,
  input  logic [ID_W-1:0] last_i,
  output logic            vld_o,
  output logic [ID_W-1:0] idx_o
);
  logic [ID_W-1:0] base;
  logic [ID_W-1:0] nxt;

  assign base = rot_i ? ID_W'(last_i + 1'b1) : '0;
  assign nxt  = ID_W'(last_i + 1'b1);

  // Walk downward so the candidate closest to base is taken last.
  always_comb begin
    logic [ID_W-1:0] cand;
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = ID_W'(base + ID_W'(k));
      if (pend_i[cand]) begin
        vld_o = 1'b1;
        idx_o = cand;
      end
    end
  end

  assert_win_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> pend_i[idx_o]);
  assert_rot_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && pend_i[nxt]) |-> (vld_o && idx_o == nxt));
  assert_fixed_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && pend_i[0]) |-> (idx_o == '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter  int N_SRC  = 64,
  parameter  int ADDR_W = 8,
  localparam int ID_W   = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  localparam int N_STAT = N_SRC / 32;
  localparam int N_CW   = N_SRC / 4;

  logic [ADDR_W-1:0] a_word;
  logic [7:0]        ctrl_q [N_SRC];
  logic [31:0]       cfg_q, cfg2_q;
  logic [N_SRC-1:0]  en_vec, lvl_vec, rise_vec, fall_vec, clr_vec;
  logic [N_SRC-1:0]  sync_vec, stat_vec, pend_vec;
  logic              irq_q, win_vld;
  logic [ID_W-1:0]   id_q, win_idx;

  assign a_word = {addr_i[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cfg2_q <= '0;
    end else if (we_i) begin
      if (a_word == ADDR_W'(A_CFG))  cfg_q  <= wdata_i;
      if (a_word == ADDR_W'(A_CFG2)) cfg2_q <= wdata_i;
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    localparam logic [ADDR_W-1:0] A_N = ADDR_W'(A_CTRL + 4 * (n / 4));
    trig_e trig;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ctrl_q[n] <= '0;
      else if (we_i && a_word == A_N)  ctrl_q[n] <= wdata_i[8*(n%4) +: 8];
    end

    assign trig        = trig_e'(ctrl_q[n][TRIG_LSB +: 2]);
    assign en_vec[n]   = ctrl_q[n][CTRL_EN_BIT];
    assign lvl_vec[n]  = (trig == TRIG_LEVEL);
    assign rise_vec[n] = (trig == TRIG_RISE) || (trig == TRIG_RISE2);
    assign fall_vec[n] = (trig == TRIG_FALL);
    assign pend_vec[n] = en_vec[n] & (lvl_vec[n] ? sync_vec[n] : stat_vec[n]);
  end

  for (genvar w = 0; w < N_STAT; w++) begin : g_clr
    assign clr_vec[32*w +: 32] =
      (we_i && a_word == ADDR_W'(A_STAT + 4 * w)) ? wdata_i : 32'h0;
  end

  irq_sync #(.W(N_SRC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_vec)
  );

  irq_edge_stat #(.N(N_SRC)) i_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_vec),
    .rise_en_i(rise_vec),
    .fall_en_i(fall_vec),
    .clr_i    (clr_vec),
    .stat_o   (stat_vec)
  );

  irq_arb #(.N(N_SRC), .ID_W(ID_W)) i_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(pend_vec),
    .rot_i (cfg_q[ROT_BIT]),
    .last_i(id_q),
    .vld_o (win_vld),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= win_vld;
      if (win_vld) id_q <= win_idx;
    end
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;

  always_comb begin
    rdata_o = '0;
    if (a_word == ADDR_W'(A_WIN))  rdata_o = {irq_q, {(31-ID_W){1'b0}}, id_q};
    if (a_word == ADDR_W'(A_CFG))  rdata_o = cfg_q;
    if (a_word == ADDR_W'(A_CFG2)) rdata_o = cfg2_q;
    for (int w = 0; w < N_CW; w++)
      if (a_word == ADDR_W'(A_CTRL + 4 * w))
        rdata_o = {ctrl_q[4*w+3], ctrl_q[4*w+2], ctrl_q[4*w+1], ctrl_q[4*w]};
    for (int w = 0; w < N_STAT; w++)
      if (a_word == ADDR_W'(A_STAT + 4 * w))
        rdata_o = stat_vec[32*w +: 32];
  end

  assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |=> !irq_o);
  assert_irq_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_vld) |=> !irq_o);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [5:0] idx;
    logic [7:0] ctrl;
    logic       pulse;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd7,  8'h08, 1'b0, 1'b1},  // level held, enabled
    '{6'd7,  8'h00, 1'b0, 1'b0},  // level, disabled
    '{6'd40, 8'h18, 1'b1, 1'b1},  // rising, pulse
    '{6'd40, 8'h28, 1'b1, 1'b1},  // falling, pulse
    '{6'd3,  8'h38, 1'b1, 1'b1},  // code 3 acts as rising
    '{6'd63, 8'h08, 1'b1, 1'b0},  // level gone low
    '{6'd12, 8'h10, 1'b1, 1'b0}   // rising, disabled
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq;
  logic [5:0]  irq_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .src_i   (src),
    .irq_o   (irq),
    .irq_id_o(irq_id)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] caddr(input int n);
    return 8'(8'h40 + 4 * (n / 4));
  endfunction

  function automatic logic [31:0] cdata(input int n, input logic [7:0] b);
    return 32'(b) << (8 * (n % 4));
  endfunction

  function automatic int nxt3(input int a);
    return (a == 5) ? 9 : (a == 9) ? 20 : 5;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1 win reg", d, 0);
    rd(8'h20, d); chk(d == 0, "R1 cfg", d, 0);
    rd(8'h24, d); chk(d == 0, "R1 cfg2", d, 0);
    rd(8'h40, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8'h7C, d); chk(d == 0, "R1 ctrl top", d, 0);
    rd(8'h80, d); chk(d == 0, "R1 stat0", d, 0);
    rd(8'h84, d); chk(d == 0, "R1 stat1", d, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    // R2 control readback
    wr(8'h44, 32'h3818_2808);
    rd(8'h44, d); chk(d == 32'h3818_2808, "R2 ctrl readback", d, 32'h3818_2808);
    wr(8'h44, 32'h0);

    // R13 free register
    wr(8'h24, 32'hA5A5_0F0F);
    rd(8'h24, d); chk(d == 32'hA5A5_0F0F, "R13 cfg2 rw", d, 32'hA5A5_0F0F);

    // vector table: R3 R4 R5 R9
    for (int i = 0; i < 7; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = !v.ctrl[3] ? "R9" : (v.ctrl[5:4] == 2'd0) ? "R3" :
            (v.ctrl[5:4] == 2'd2) ? "R5" : "R4";
      wr(caddr(int'(v.idx)), cdata(int'(v.idx), v.ctrl));
      @(negedge clk); src[v.idx] = 1'b1;
      repeat (4) @(negedge clk);
      if (v.pulse) src[v.idx] = 1'b0;
      repeat (5) @(negedge clk);
      chk(irq == v.exp_irq, tag, 32'(irq), 32'(v.exp_irq));
      if (v.exp_irq) chk(irq_id == v.idx, tag, 32'(irq_id), 32'(v.idx));
      wr(caddr(int'(v.idx)), 32'h0);
      src = '0;
      repeat (4) @(negedge clk);
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h84, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
    end

    // R3 latency: level source 1, irq on third edge
    wr(8'h40, cdata(1, 8'h08));
    @(negedge clk); src[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R3 not before third edge", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1, "R3 third edge", 32'(irq), 1);
    src[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq == 0, "R3 drop", 32'(irq), 0);
    wr(8'h40, 32'h0);

    // R6 R9: disabled rising source 33 still latches in upper word
    wr(caddr(33), cdata(33, 8'h10));
    @(negedge clk); src[33] = 1'b1;
    repeat (4) @(negedge clk); src[33] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h84, d); chk(d == 32'h2, "R6 upper word", d, 32'h2);
    rd(8'h80, d); chk(d == 32'h0, "R6 lower word", d, 32'h0);
    chk(irq == 0, "R9 disabled no irq", 32'(irq), 0);

    // R7 write-one-to-clear
    wr(8'h84, 32'h0);
    rd(8'h84, d); chk(d == 32'h2, "R7 zero keeps", d, 32'h2);
    wr(8'h84, 32'h2);
    rd(8'h84, d); chk(d == 32'h0, "R7 one clears", d, 32'h0);
    wr(caddr(33), 32'h0);

    // R8 edge and clear in the same cycle
    wr(8'h40, cdata(2, 8'h18));
    @(negedge clk); src[2] = 1'b1;
    repeat (4) @(negedge clk); src[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h80, d); chk(d == 32'h4, "R8 pre latch", d, 32'h4);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 8'h80; wdata = 32'h4;
    @(negedge clk); we = 1'b0;
    rd(8'h80, d); chk(d == 32'h4, "R8 set wins", d, 32'h4);
    wr(8'h40, 32'h0);
    src = '0;
    repeat (4) @(negedge clk);
    wr(8'h80, 32'hFFFF_FFFF);

    // R10 fixed priority with sources 5, 9, 20
    wr(caddr(5),  cdata(5, 8'h08));
    wr(caddr(9),  cdata(9, 8'h08));
    wr(caddr(20), cdata(20, 8'h08));
    @(negedge clk); src[5] = 1'b1; src[9] = 1'b1; src[20] = 1'b1;
    repeat (5) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(irq == 1 && irq_id == 6'd5, "R10 lowest wins", 32'(irq_id), 5);
      @(negedge clk);
    end

    // R12 winner register
    rd(8'h00, d); chk(d == 32'h8000_0005, "R12 win read", d, 32'h8000_0005);

    // R11 rotating priority
    wr(8'h20, 32'h40);
    repeat (2) @(negedge clk);
    a = int'(irq_id);
    chk(a == 5 || a == 9 || a == 20, "R11 member", 32'(a), 5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      b = int'(irq_id);
      chk(b == nxt3(a), "R11 rotation", 32'(b), 32'(nxt3(a)));
      a = b;
    end
    rd(8'h00, d); chk(d == {1'b1, 25'h0, 6'(a)}, "R12 win read rot", d, {1'b1, 25'h0, 6'(a)});

    wr(8'h20, 32'h0);
    src = '0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule